// File: doc/BRIEF.md
# Serial MAC Compatibility Adapter

This block sits between one port's serial NRZ transceiver datapath and an external 10 Mb/s MAC controller. Controllers differ in several ways: the clock edge they use to present or take data, the polarity of the collision and loopback pins, the level of receive data while no carrier is present, and how long the receive clock keeps running after carrier ends. The adapter supports four compatibility profiles and shapes the MAC-facing signals to match whichever profile is active.

The block runs from a core clock at twice the bit rate. The transmit and receive bit clocks are produced as alternating phases of that core clock, so picking a rising or a falling bit-clock edge is the same as picking one of the two core-clock phases. A 3-bit profile code is loaded from strap pins while reset is held. A host can replace it later with a write. The new code is held back until neither a received nor a transmitted frame is in progress, so one frame is never handled under two profiles. Captured transmit bits leave on a valid strobe without ready. The serial line cannot stall, so back-pressure is not possible: a consumer must accept every beat for which `tx_valid_o` is high.

Top module: `serial_mac_adapter`

## Requirements
- R1: Profile codes 111, 001, 010 and 011 select profiles 1 to 4, reported on `mode_o` as 0, 1, 2 and 3. While reset is held, the strap code is loaded, and any other strap code gives profile 1.
- R2: In profile 1, `rxc_o` gives exactly 5 further pulses after `crs_o` falls and then stays low. In profile 2, no pulse follows the fall of `crs_o`.
- R3: In profiles 3 and 4, `rxc_o` toggles every core cycle whether or not carrier is present.
- R4: `txd_pin` and `txe_pin` are captured on the rising `txc_o` edge in profiles 1 and 2 and on the falling edge in profiles 3 and 4. `tx_valid_o` is high for one cycle with each new capture, and the transmit enable is active high.
- R5: `rxd_o` and `crs_o` change only when `rxc_o` falls in profiles 1 to 3, and only when it rises in profile 4.
- R6: While `crs_o` is low, `rxd_o` is 1 in profile 2 and 0 in the other profiles. `crs_o` is active high in all profiles.
- R7: `col_o` is active low in profile 4 and active high otherwise. It follows the collision input one core cycle later.
- R8: `lpbk_o` is the active-high internal loopback request. `lpbk_pin` is taken as active low in profile 3 and as active high otherwise.
- R9: When a capture sees transmit enable drop, a collision test indication is driven on `col_o` for SQE_CYCLES core cycles (1 us at a 20 MHz core clock).
- R10: A host write with a valid code takes effect only while `crs_o` and `tx_en_o` are both low, and a write made during a frame is held until then. A write with any other code is ignored.
- R11: `txc_o` is a square wave with a period of two core cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bit rate |
| rst_n | input | 1 | Active-low reset; the strap code is loaded while it is low |
| strap_code | input | 3 | Profile code from the strap pins |
| host_wr | input | 1 | One-cycle host write strobe |
| host_code | input | 3 | Profile code for a host write |
| rx_data_i | input | 1 | Recovered receive bit from the decoder |
| rx_carrier_i | input | 1 | Internal carrier-present indication |
| rx_col_i | input | 1 | Internal collision indication |
| lpbk_pin | input | 1 | Loopback request from the MAC; polarity depends on the profile |
| txd_pin | input | 1 | Transmit data from the MAC |
| txe_pin | input | 1 | Transmit enable from the MAC |
| txc_o | output | 1 | Transmit bit clock to the MAC |
| rxc_o | output | 1 | Gated receive bit clock to the MAC |
| rxd_o | output | 1 | Receive data to the MAC |
| crs_o | output | 1 | Carrier sense to the MAC |
| col_o | output | 1 | Collision to the MAC; polarity depends on the profile |
| lpbk_o | output | 1 | Internal loopback request, active high |
| tx_data_o | output | 1 | Captured transmit bit |
| tx_en_o | output | 1 | Captured transmit enable |
| tx_valid_o | output | 1 | High for one cycle per new capture |
| mode_o | output | 2 | Active profile index |

## Verification
The hardest state to reach from the ports is a host write that arrives while a frame is active and has to wait. The stimulus starts a receive frame, writes a new code partway through, and confirms that `mode_o` holds until carrier has ended. Counting clock pulses after the carrier drop in profile 1 and profile 2 checks the exact end of the receive-clock tail. A behavioural cycle model then follows each profile through frames, collision pulses and loopback, and compares every output on every clock.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic [1:0] {
    CM_1 = 2'd0,
    CM_2 = 2'd1,
    CM_3 = 2'd2,
    CM_4 = 2'd3
  } compat_e;

  function automatic logic code_known(input logic [2:0] c);
    return (c == 3'b111) || (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
  endfunction

  function automatic compat_e code_to_mode(input logic [2:0] c);
    case (c)
      3'b001:  return CM_2;
      3'b010:  return CM_3;
      3'b011:  return CM_4;
      default: return CM_1;
    endcase
  endfunction
endpackage

// File: rtl/smac_mode_ctrl.sv
module smac_mode_ctrl
  import smac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_code,
  input  logic       wr_en,
  input  logic [2:0] wr_code,
  input  logic       idle,
  output compat_e    mode
);
  compat_e mode_q, pend_q;
  logic    pend_v;
  logic    wr_ok;

  assign wr_ok = wr_en && code_known(wr_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= code_to_mode(strap_code);
      pend_q <= CM_1;
      pend_v <= 1'b0;
    end else begin
      if (wr_ok) begin
        pend_q <= code_to_mode(wr_code);
        pend_v <= 1'b1;
      end else if (pend_v && idle) begin
        pend_v <= 1'b0;
      end
      if (pend_v && idle) mode_q <= pend_q;
    end
  end

  assign mode = mode_q;

  // R10: the profile only moves while no frame is in progress
  a_r10_idle_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(idle));
endmodule

// File: rtl/smac_tx_path.sv
module smac_tx_path
  import smac_pkg::*;
#(
  parameter int SQE_CYC = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ph,
  input  compat_e mode,
  input  logic    txd_i,
  input  logic    txe_i,
  output logic    txd_q,
  output logic    txe_q,
  output logic    valid_q,
  output logic    sqe_on
);
  localparam int SW = $clog2(SQE_CYC + 1);

  logic          rise_mode;
  logic          strobe;
  logic [SW-1:0] sqe_cnt;

  assign rise_mode = (mode == CM_1) || (mode == CM_2);
  assign strobe    = rise_mode ? !ph : ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= 1'b0;
      txe_q   <= 1'b0;
      valid_q <= 1'b0;
      sqe_cnt <= '0;
    end else begin
      valid_q <= strobe;
      if (strobe) begin
        txd_q <= txd_i;
        txe_q <= txe_i;
      end
      if (strobe && txe_q && !txe_i) sqe_cnt <= SW'(SQE_CYC);
      else if (sqe_cnt != '0)        sqe_cnt <= sqe_cnt - 1'b1;
    end
  end

  assign sqe_on = (sqe_cnt != '0);

  // R4: a fresh capture lines up with the edge the profile samples on
  a_r4_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (ph == (($past(mode) == CM_1) || ($past(mode) == CM_2))));
  // R9: the test pulse counter stays within its window
  a_r9_sqe_window: assert property (@(posedge clk) disable iff (!rst_n)
    (sqe_cnt <= SW'(SQE_CYC)));
endmodule

// File: rtl/smac_rx_path.sv
module smac_rx_path
  import smac_pkg::*;
#(
  parameter int TAIL = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ph,
  input  compat_e mode,
  input  logic    data_i,
  input  logic    carrier_i,
  input  logic    col_i,
  input  logic    sqe_on,
  output logic    rxc_o,
  output logic    rxd_o,
  output logic    crs_o,
  output logic    col_o
);
  localparam int TW = $clog2(TAIL + 1);

  logic          launch;
  logic          crs_q, rxd_q, col_q, gate_q;
  logic [TW-1:0] tail_q;

  assign launch = (mode == CM_4) ? !ph : ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q  <= 1'b0;
      rxd_q  <= 1'b0;
      col_q  <= 1'b0;
      gate_q <= 1'b0;
      tail_q <= '0;
    end else begin
      if (launch) begin
        crs_q <= carrier_i;
        rxd_q <= data_i;
      end
      col_q <= (col_i | sqe_on) ^ (mode == CM_4);
      if (ph) begin
        case (mode)
          CM_1: begin
            if (carrier_i) begin
              tail_q <= TW'(TAIL);
              gate_q <= 1'b1;
            end else if (tail_q != '0) begin
              tail_q <= tail_q - 1'b1;
              gate_q <= 1'b1;
            end else begin
              gate_q <= 1'b0;
            end
          end
          CM_2: begin
            gate_q <= carrier_i;
            tail_q <= '0;
          end
          default: begin
            gate_q <= 1'b1;
            tail_q <= '0;
          end
        endcase
      end
    end
  end

  assign rxc_o = gate_q & ph;
  assign rxd_o = crs_q ? rxd_q : (mode == CM_2);
  assign crs_o = crs_q;
  assign col_o = col_q;

  // R3: continuous profiles keep the receive clock enabled
  a_r3_free_running: assert property (@(posedge clk) disable iff (!rst_n)
    (ph && ((mode == CM_3) || (mode == CM_4))) |=> gate_q);
  // R2: profile 2 adds no clocks once carrier is gone
  a_r2_no_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (ph && (mode == CM_2) && !carrier_i) |=> !gate_q);
  // R7: profile 4 holds the collision line high when nothing collides
  a_r7_col_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == CM_4) && !col_i && !sqe_on) |=> col_o);
endmodule

// File: rtl/serial_mac_adapter.sv
module serial_mac_adapter
  import smac_pkg::*;
#(
  parameter int SQE_CYCLES = 20,
  parameter int RXC_TAIL   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_code,
  input  logic       host_wr,
  input  logic [2:0] host_code,
  input  logic       rx_data_i,
  input  logic       rx_carrier_i,
  input  logic       rx_col_i,
  input  logic       lpbk_pin,
  input  logic       txd_pin,
  input  logic       txe_pin,
  output logic       txc_o,
  output logic       rxc_o,
  output logic       rxd_o,
  output logic       crs_o,
  output logic       col_o,
  output logic       lpbk_o,
  output logic       tx_data_o,
  output logic       tx_en_o,
  output logic       tx_valid_o,
  output logic [1:0] mode_o
);
  compat_e mode;
  logic    ph;
  logic    sqe_on;
  logic    idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= !ph;
  end

  assign idle = !crs_o && !tx_en_o;

  smac_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_code(strap_code),
    .wr_en     (host_wr),
    .wr_code   (host_code),
    .idle      (idle),
    .mode      (mode)
  );

  smac_tx_path #(.SQE_CYC(SQE_CYCLES)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (ph),
    .mode   (mode),
    .txd_i  (txd_pin),
    .txe_i  (txe_pin),
    .txd_q  (tx_data_o),
    .txe_q  (tx_en_o),
    .valid_q(tx_valid_o),
    .sqe_on (sqe_on)
  );

  smac_rx_path #(.TAIL(RXC_TAIL)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .mode     (mode),
    .data_i   (rx_data_i),
    .carrier_i(rx_carrier_i),
    .col_i    (rx_col_i),
    .sqe_on   (sqe_on),
    .rxc_o    (rxc_o),
    .rxd_o    (rxd_o),
    .crs_o    (crs_o),
    .col_o    (col_o)
  );

  assign txc_o  = ph;
  assign lpbk_o = lpbk_pin ^ (mode == CM_3);
  assign mode_o = mode;

  // R11: the bit clock changes level on every core cycle
  a_r11_txc_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txc_o) || $past(!rst_n));
endmodule

// File: tb/serial_mac_adapter_bench.sv
module serial_mac_adapter_bench;
  localparam int SQE = 20;
  localparam int TL  = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, host_wr, rx_data_i, rx_carrier_i, rx_col_i, lpbk_pin, txd_pin, txe_pin;
  logic [2:0] strap_code, host_code;
  logic       txc_o, rxc_o, rxd_o, crs_o, col_o, lpbk_o, tx_data_o, tx_en_o, tx_valid_o;
  logic [1:0] mode_o;

  serial_mac_adapter #(.SQE_CYCLES(SQE), .RXC_TAIL(TL)) u_serial_mac_adapter (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .host_wr(host_wr),
    .host_code(host_code), .rx_data_i(rx_data_i), .rx_carrier_i(rx_carrier_i),
    .rx_col_i(rx_col_i), .lpbk_pin(lpbk_pin), .txd_pin(txd_pin), .txe_pin(txe_pin),
    .txc_o(txc_o), .rxc_o(rxc_o), .rxd_o(rxd_o), .crs_o(crs_o), .col_o(col_o),
    .lpbk_o(lpbk_o), .tx_data_o(tx_data_o), .tx_en_o(tx_en_o),
    .tx_valid_o(tx_valid_o), .mode_o(mode_o)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  // behavioural reference state, profiles numbered 0..3
  int m_ph, m_mode, m_pv, m_pend, m_txd, m_txe, m_val, m_sqe;
  int m_gate, m_tail, m_crs, m_rxd, m_col;

  function automatic int dec(input logic [2:0] c);
    if (c == 3'b001) return 1;
    if (c == 3'b010) return 2;
    if (c == 3'b011) return 3;
    return 0;
  endfunction

  function automatic bit known(input logic [2:0] c);
    return (c == 3'b111) || (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
  endfunction

  always @(posedge clk) begin : ref_model
    int n_mode, n_pv, n_pend, n_txd, n_txe, n_val, n_sqe, n_gate, n_tail, n_crs, n_rxd, n_col;
    bit strobe, launch, idle;
    if (!rst_n) begin
      m_mode = dec(strap_code); m_pv = 0; m_pend = 0; m_ph = 0;
      m_txd = 0; m_txe = 0; m_val = 0; m_sqe = 0;
      m_gate = 0; m_tail = 0; m_crs = 0; m_rxd = 0; m_col = 0;
    end else begin
      n_mode = m_mode; n_pv = m_pv; n_pend = m_pend; n_txd = m_txd; n_txe = m_txe;
      n_sqe = m_sqe; n_gate = m_gate; n_tail = m_tail; n_crs = m_crs; n_rxd = m_rxd;
      idle   = (m_crs == 0) && (m_txe == 0);
      strobe = (m_mode < 2) ? (m_ph == 0) : (m_ph == 1);
      n_val  = strobe;
      if (strobe) begin n_txd = txd_pin; n_txe = txe_pin; end
      if (strobe && m_txe == 1 && !txe_pin) n_sqe = SQE;
      else if (m_sqe > 0) n_sqe = m_sqe - 1;
      n_col  = ((rx_col_i | (m_sqe != 0)) ^ (m_mode == 3)) ? 1 : 0;
      launch = (m_mode == 3) ? (m_ph == 0) : (m_ph == 1);
      if (launch) begin n_crs = rx_carrier_i; n_rxd = rx_data_i; end
      if (m_ph == 1) begin
        if (m_mode == 0) begin
          if (rx_carrier_i) begin n_tail = TL; n_gate = 1; end
          else if (m_tail > 0) begin n_tail = m_tail - 1; n_gate = 1; end
          else n_gate = 0;
        end else if (m_mode == 1) begin n_gate = rx_carrier_i; n_tail = 0; end
        else begin n_gate = 1; n_tail = 0; end
      end
      if (host_wr && known(host_code)) begin n_pend = dec(host_code); n_pv = 1; end
      else if (m_pv == 1 && idle) n_pv = 0;
      if (m_pv == 1 && idle) n_mode = m_pend;
      m_mode = n_mode; m_pv = n_pv; m_pend = n_pend; m_txd = n_txd; m_txe = n_txe;
      m_val = n_val; m_sqe = n_sqe; m_gate = n_gate; m_tail = n_tail; m_crs = n_crs;
      m_rxd = n_rxd; m_col = n_col; m_ph = 1 - m_ph;
    end
  end

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", what, $time, act, exp);
    end
  endtask

  task automatic cmp_all();
    if (!cmp_on) return;
    chk(4'(txc_o), 4'(m_ph), "R11 txc_o");
    chk(4'(rxc_o), 4'(m_gate & m_ph), "R2/R3 rxc_o");
    chk(4'(rxd_o), 4'(m_crs ? m_rxd : (m_mode == 1)), "R5/R6 rxd_o");
    chk(4'(crs_o), 4'(m_crs), "R5 crs_o");
    chk(4'(col_o), 4'(m_col), "R7/R9 col_o");
    chk(4'(lpbk_o), 4'(lpbk_pin ^ (m_mode == 2)), "R8 lpbk_o");
    chk(4'(tx_data_o), 4'(m_txd), "R4 tx_data_o");
    chk(4'(tx_en_o), 4'(m_txe), "R4 tx_en_o");
    chk(4'(tx_valid_o), 4'(m_val), "R4 tx_valid_o");
    chk(4'(mode_o), 4'(m_mode), "R1/R10 mode_o");
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic do_reset(input logic [2:0] strap);
    cmp_on = 0; rst_n = 0; strap_code = strap;
    tick(4);
    rst_n = 1;
    tick(1);
    cmp_on = 1;
    tick(1);
  endtask

  task automatic host_write(input logic [2:0] c);
    host_wr = 1; host_code = c; tick(1);
    host_wr = 0; tick(1);
  endtask

  task automatic rx_bits(input int n, input logic [15:0] pat);
    rx_carrier_i = 1;
    for (int i = 0; i < n; i++) begin
      rx_data_i = pat[i % 16];
      tick(2);
    end
    rx_carrier_i = 0; rx_data_i = 0;
  endtask

  task automatic tail_count(input int exp, input string tag);
    int rises;
    logic prev;
    for (int i = 0; i < 10 && crs_o !== 1'b0; i++) tick(1);
    rises = 0; prev = rxc_o;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (rxc_o && !prev) rises++;
      prev = rxc_o;
    end
    chk(4'(rises), 4'(exp), tag);
  endtask

  task automatic tx_frame(input int n, input logic [15:0] pat);
    txe_pin = 1;
    for (int i = 0; i < n; i++) begin
      txd_pin = pat[i % 16];
      tick(2);
    end
    txe_pin = 0; txd_pin = 0;
  endtask

  initial begin
    rst_n = 0; strap_code = 3'b111; host_wr = 0; host_code = 3'b000;
    rx_data_i = 0; rx_carrier_i = 0; rx_col_i = 0; lpbk_pin = 0; txd_pin = 0; txe_pin = 0;
    do_reset(3'b111);
    // R1 reset state: profile 1, nothing active
    chk(4'(mode_o), 4'd0, "R1 strap 111 gives profile 1");
    chk(4'(crs_o), 4'd0, "R6 crs low after reset");
    chk(4'(tx_en_o), 4'd0, "R4 tx enable low after reset");
    lpbk_pin = 1; tick(2);
    chk(4'(lpbk_o), 4'd1, "R8 active-high loopback in profile 1");
    lpbk_pin = 0;

    rx_bits(12, 16'hA5C3);
    tail_count(TL, "R2 profile 1 tail pulses");

    begin : sqe_m1
      int act;
      tx_frame(8, 16'h3C96);
      act = 0;
      for (int i = 0; i < 40; i++) begin tick(1); if (col_o) act++; end
      chk(4'(act), 4'(SQE), "R9 test pulse length");
    end

    host_write(3'b001); tick(3);
    chk(4'(mode_o), 4'd1, "R10 idle write applies");
    chk(4'(rxd_o), 4'd1, "R6 profile 2 idle high");
    rx_bits(10, 16'h5A0F);
    tail_count(0, "R2 profile 2 no tail");

    rx_carrier_i = 1; rx_data_i = 1; tick(6);
    host_write(3'b010); tick(6);
    chk(4'(mode_o), 4'd1, "R10 write held during frame");
    rx_bits(6, 16'h0F0F);
    tick(6);
    chk(4'(mode_o), 4'd2, "R10 held write lands after frame");

    lpbk_pin = 0; tick(2);
    chk(4'(lpbk_o), 4'd1, "R8 active-low loopback in profile 3");
    tail_count(15, "R3 profile 3 continuous clock");
    tx_frame(6, 16'hB2E1);
    tick(44);
    host_write(3'b101); tick(3);
    chk(4'(mode_o), 4'd2, "R10 unknown code ignored");

    host_write(3'b011); tick(3);
    chk(4'(mode_o), 4'd3, "R1 code 011 gives profile 4");
    chk(4'(col_o), 4'd1, "R7 profile 4 col idle high");
    rx_col_i = 1; tick(2);
    chk(4'(col_o), 4'd0, "R7 profile 4 col active low");
    rx_col_i = 0;
    rx_bits(9, 16'h6D29);
    tail_count(15, "R3 profile 4 continuous clock");
    tx_frame(5, 16'h1234);
    tick(44);

    do_reset(3'b011);
    chk(4'(mode_o), 4'd3, "R1 strap 011 gives profile 4");
    do_reset(3'b000);
    chk(4'(mode_o), 4'd0, "R1 unknown strap gives profile 1");
    rx_bits(4, 16'h0009);
    tick(20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule